// File: doc/BRIEF.md
# Periodic Second Insert/Swallow Adjuster

This block sits between a one-second tick source and a real-time seconds counter and corrects slow drift in whole seconds. A configuration word selects a correction interval, a direction and an enable. While the correction is enabled, the block counts incoming seconds. On every (interval + 1)-th second it either makes the downstream counter advance by two (one second added) or suppresses the tick so that the counter does not move (one second dropped). An interval value of N gives a correction of about 1e9/(N+1) parts per billion. Adding a second is a positive offset and dropping one is a negative offset.

Each incoming tick produces, one clock later, an advance strobe and an advance amount for the counter. A write to the configuration word restarts the interval count. The field layout follows the interval width. With the default width of 19 bits, the interval sits in bits 18:0, the direction code in bits 20:19 and the enable in bit 23, in a 24-bit word.

Top module: `sec_trim_adjust`

## Requirements
- R1: After a synchronous active-low reset, the advance strobe `adv_strobe` and the amount `adv_amt` are 0, and the interval count is zero.
- R2: While the enable bit (bit MATCH_W+4, bit 23 by default) is 0, every tick passes unchanged with an advance amount of 1, whatever the other fields hold.
- R3: While the enable bit is 1 and the direction code (bits MATCH_W+1:MATCH_W, bits 20:19 by default) is 0 or 1, every tick passes unchanged with an advance amount of 1.
- R4: With the enable bit set, direction code 3 (insert) and interval field value N (bits MATCH_W-1:0), every (N+1)-th tick gives an advance amount of 2. All other ticks give an amount of 1.
- R5: With the enable bit set and direction code 2 (swallow), every (N+1)-th tick is suppressed: `adv_strobe` stays 0 and `adv_amt` is 0. All other ticks give an amount of 1.
- R6: Over k·(N+1) ticks after a write, the summed advance is exactly k·(N+1)+k for insert and k·(N+1)−k for swallow.
- R7: A configuration write clears the interval count. A tick in the same cycle as the write passes with an amount of 1 and is not counted, and the first event then falls on the (N+1)-th tick after the write.
- R8: With N = 0, every tick is an event: each tick gives an amount of 2 for insert, and no tick gives an advance for swallow.
- R9: `adv_strobe` is high only in the clock cycle right after a tick. It lasts one cycle, and `adv_amt` is 0 whenever `adv_strobe` is low.
- R10: With N at its largest value (all ones), the first event falls on tick 2^MATCH_W, and the count never exceeds N.
- R11: Bits MATCH_W+3:MATCH_W+2 (bits 22:21 by default) have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | Raw one-second tick, one cycle wide |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | MATCH_W+5 | Configuration word: interval, direction code, spare bits, enable |
| adv_strobe | output | 1 | The seconds counter should advance this cycle |
| adv_amt | output | 2 | Advance amount: 0, 1 or 2 |

## Verification
The bench builds the block with MATCH_W = 5, which gives a 10-bit configuration word. This puts the largest interval (31, an event every 32 ticks) within a short run, so the all-ones boundary case of R10 is covered along with the small intervals 0, 1, 3 and 4. With these small values, the bench can check the totals of R6 over several whole correction periods. It also checks each tick's amount against a count kept in the bench, including a tick that arrives in the same cycle as a rewrite.

// File: rtl/sec_trim_pkg.sv
// Shared types for the second trim adjuster.
// Assumes a two-bit direction code; only the two upper codes act.
package sec_trim_pkg;
    typedef enum logic [1:0] {
        DIR_NONE_A  = 2'd0,
        DIR_NONE_B  = 2'd1,
        DIR_SWALLOW = 2'd2,
        DIR_INSERT  = 2'd3
    } trim_dir_e;

    localparam int unsigned DIR_W   = 2;
    localparam int unsigned SPARE_W = 2;
endpackage

// File: rtl/sec_trim_cfg.sv
// Configuration holder: stores the trim word on a write and decodes it
// into interval, direction and an "active" flag.
// Assumes the layout: interval in low MATCH_W bits, then direction,
// then two spare bits, then the enable bit at the top.
module sec_trim_cfg
    import sec_trim_pkg::*;
#(
    parameter int unsigned MATCH_W = 19,
    localparam int unsigned CFG_W  = MATCH_W + DIR_W + SPARE_W + 1,
    localparam int unsigned DIR_LSB = MATCH_W,
    localparam int unsigned EN_BIT  = CFG_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CFG_W-1:0]   wdata,
    output logic [MATCH_W-1:0] match,
    output trim_dir_e          dir,
    output logic               active
);
    logic [MATCH_W-1:0] match_q;
    logic [DIR_W-1:0]   dir_q;
    logic               en_q;

    // Capture the fields of the configuration word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            dir_q   <= '0;
            en_q    <= 1'b0;
        end else if (wr) begin
            match_q <= wdata[MATCH_W-1:0];
            dir_q   <= wdata[DIR_LSB +: DIR_W];
            en_q    <= wdata[EN_BIT];
        end
    end

    // Decode: correction acts only when enabled with an acting direction code.
    always_comb begin
        match  = match_q;
        dir    = trim_dir_e'(dir_q);
        active = en_q && (dir == DIR_SWALLOW || dir == DIR_INSERT);
    end
endmodule

// File: rtl/sec_trim_interval.sv
// Interval counter: counts the ticks seen while the correction is active
// and flags the tick that closes each window of match+1 ticks.
// Assumes a write clears the count; a tick in the write cycle is not counted.
module sec_trim_interval #(
    parameter int unsigned MATCH_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               clear,
    input  logic               active,
    input  logic [MATCH_W-1:0] match,
    output logic               hit
);
    logic [MATCH_W-1:0] cnt_q;

    // Flag the tick that closes the current window.
    always_comb begin
        hit = tick && active && !clear && (cnt_q == match);
    end

    // Advance the window count, wrapping to zero after each event.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end

    // R10: the count never passes the programmed interval
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= match));

    // R3: with no acting correction the count rests at zero
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cnt_q == '0));

    // R7: the cycle after a write starts from an empty window
    a_r7_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/sec_trim_out.sv
// Output stage: turns a tick into a registered advance strobe and amount
// for the seconds counter.
// Assumes the hit flag is only high together with a tick.
module sec_trim_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hit,
    input  logic       insert,
    output logic       adv_strobe,
    output logic [1:0] adv_amt
);
    // Register the advance: 1 normally, 2 on insert, none on swallow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_strobe <= 1'b0;
            adv_amt    <= 2'd0;
        end else if (!tick) begin
            adv_strobe <= 1'b0;
            adv_amt    <= 2'd0;
        end else if (hit) begin
            adv_strobe <= insert;
            adv_amt    <= insert ? 2'd2 : 2'd0;
        end else begin
            adv_strobe <= 1'b1;
            adv_amt    <= 2'd1;
        end
    end

    // R9: a strobe always follows a tick in the previous cycle
    a_r9_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        adv_strobe |-> $past(tick));

    // R9: the amount is zero whenever no strobe is given
    a_r9_amt_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_strobe |-> (adv_amt == 2'd0));

    // R5: a swallow event produces no advance
    a_r5_swallow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && hit && !insert) |=> !adv_strobe);
endmodule

// File: rtl/sec_trim_adjust.sv
// Top of the second trim adjuster: holds the trim word, counts correction
// windows and shapes the advance handed to the seconds counter.
// Assumes sec_tick is a single-cycle pulse in the clk domain.
module sec_trim_adjust
    import sec_trim_pkg::*;
#(
    parameter int unsigned MATCH_W = 19,
    localparam int unsigned CFG_W  = MATCH_W + DIR_W + SPARE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             adv_strobe,
    output logic [1:0]       adv_amt
);
    logic [MATCH_W-1:0] match;
    trim_dir_e          dir;
    logic               active;
    logic               hit;
    logic               insert;

    sec_trim_cfg #(.MATCH_W(MATCH_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .match  (match),
        .dir    (dir),
        .active (active)
    );

    sec_trim_interval #(.MATCH_W(MATCH_W)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .clear  (cfg_wr),
        .active (active),
        .match  (match),
        .hit    (hit)
    );

    // Select the direction of an event.
    always_comb begin
        insert = (dir == DIR_INSERT);
    end

    sec_trim_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sec_tick),
        .hit        (hit),
        .insert     (insert),
        .adv_strobe (adv_strobe),
        .adv_amt    (adv_amt)
    );

    // R2: with no acting correction a tick passes as a single advance
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !active) |=> (adv_strobe && adv_amt == 2'd1));

    // R7: a tick in a write cycle passes unadjusted
    a_r7_write_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && cfg_wr) |=> (adv_strobe && adv_amt == 2'd1));
endmodule

// File: tb/sec_trim_adjust_tb.sv
module sec_trim_adjust_tb;
    localparam int MW = 5;
    localparam int CW = MW + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          adv_strobe;
    logic [1:0]    adv_amt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sec_trim_adjust #(.MATCH_W(MW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .adv_strobe (adv_strobe),
        .adv_amt    (adv_amt)
    );

    function automatic logic [CW-1:0] mk(input bit en, input logic [1:0] spare,
                                         input logic [1:0] dir, input int n);
        return {en, spare, dir, n[MW-1:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [CW-1:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One tick; returns the advance seen in the following cycle.
    task automatic tick(output int amt, output bit strobe);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        amt = adv_amt;
        strobe = adv_strobe;
        @(negedge clk);
    endtask

    // Run n ticks, checking each against interval n_int and kind (0 none,2 swallow,3 insert).
    task automatic run(input string req, input int n, input int n_int, input int kind,
                       output int sum);
        sum = 0;
        for (int i = 1; i <= n; i++) begin
            int a; bit s; int e;
            tick(a, s);
            e = 1;
            if (kind != 0 && (i % (n_int + 1)) == 0) e = (kind == 3) ? 2 : 0;
            chk(req, a, e);
            chk(req, s, (e != 0) ? 1 : 0);
            sum += a;
        end
    endtask

    task automatic t_reset();
        chk("R1 strobe", adv_strobe, 0);
        chk("R1 amt", adv_amt, 0);
    endtask

    task automatic t_bypass();
        int s;
        wr_cfg(mk(0, 2'b00, 2'd3, 0));
        run("R2", 6, 0, 0, s);
        chk("R2 sum", s, 6);
    endtask

    task automatic t_mode_off();
        int s;
        wr_cfg(mk(1, 2'b00, 2'd0, 0));
        run("R3 code0", 4, 0, 0, s);
        wr_cfg(mk(1, 2'b00, 2'd1, 1));
        run("R3 code1", 4, 1, 0, s);
        chk("R3 sum", s, 4);
    endtask

    task automatic t_insert();
        int s;
        wr_cfg(mk(1, 2'b00, 2'd3, 3));
        run("R4", 16, 3, 3, s);
        chk("R6 insert total", s, 16 + 4);
    endtask

    task automatic t_swallow();
        int s;
        wr_cfg(mk(1, 2'b00, 2'd2, 4));
        run("R5", 15, 4, 2, s);
        chk("R6 swallow total", s, 15 - 3);
    endtask

    task automatic t_rewrite();
        int s, a; bit st;
        wr_cfg(mk(1, 2'b00, 2'd3, 3));
        run("R7 pre", 2, 3, 3, s);
        // tick coinciding with a rewrite
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = mk(1, 2'b00, 2'd3, 3);
        sec_tick = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        sec_tick = 1'b0;
        a = adv_amt;
        st = adv_strobe;
        chk("R7 write tick amt", a, 1);
        chk("R7 write tick strobe", st, 1);
        run("R7 post", 8, 3, 3, s);
        chk("R7 sum", s, 10);
    endtask

    task automatic t_zero();
        int s;
        wr_cfg(mk(1, 2'b00, 2'd3, 0));
        run("R8 insert", 5, 0, 3, s);
        chk("R8 insert sum", s, 10);
        wr_cfg(mk(1, 2'b00, 2'd2, 0));
        run("R8 swallow", 5, 0, 2, s);
        chk("R8 swallow sum", s, 0);
    endtask

    task automatic t_max();
        int s;
        wr_cfg(mk(1, 2'b00, 2'd3, (1 << MW) - 1));
        run("R10", 2 << MW, (1 << MW) - 1, 3, s);
        chk("R10 sum", s, (2 << MW) + 2);
    endtask

    task automatic t_spare();
        int s;
        wr_cfg(mk(1, 2'b11, 2'd3, 1));
        run("R11 spare set", 6, 1, 3, s);
        chk("R11 sum", s, 9);
        wr_cfg(mk(1, 2'b10, 2'd2, 1));
        run("R11 spare swallow", 4, 1, 2, s);
    endtask

    task automatic t_idle();
        int a; bit st;
        wr_cfg(mk(1, 2'b00, 2'd3, 0));
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 no tick strobe", adv_strobe, 0);
            chk("R9 no tick amt", adv_amt, 0);
        end
        tick(a, st);
        chk("R9 after tick", st, 1);
        chk("R9 one cycle", adv_strobe, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_mode_off();
        t_insert();
        t_swallow();
        t_rewrite();
        t_zero();
        t_max();
        t_spare();
        t_idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule